// File: doc/BRIEF.md
# Page protection ID checker

This block sits beside the address translation stage and filters each translated access against the page's protection identifier. It keeps four writable protection-ID registers. Each one holds an identifier in bits [31:1] and a write-disable flag in bit 0. When protection checking is enabled and the translated page carries a non-zero access identifier, the block compares that identifier against all four registers. A register matches only when its upper bits equal the identifier and its low bit is set. On a match the block drops write permission, and it raises a protection fault if the access itself is a write.

The block also tells the translation cache when its cached results have gone stale. It issues a one-cycle flush pulse with an all-contexts mask in two cases. The first is when a protection-ID register is written while checking is enabled. The second is when the protection-enable bit changes in either direction. The permission path is purely combinational and valid in the same cycle as the access strobe. The register file and the flush path are clocked, with a synchronous active-high reset.

Top module: `prot_id_guard`

## Requirements
- R1: After reset, all four protection-ID registers read as zero, flush_req is 0, flush_mask is 0, and the remembered enable state is 0.
- R2: A control write lands in a protection-ID register only when cr_idx is 8, 9, 12 or 13. A write to any other index, for example 10, leaves matching unchanged and requests no flush.
- R3: While psw_prot_en is 0, perm_out equals perm_in and prot_fault is 0 for every access.
- R4: An access whose acc_id is zero is public. perm_out equals perm_in and prot_fault is 0, even when some register holds the value 1.
- R5: A register matches only if bits [31:1] equal acc_id and bit 0 is 1. A register holding the identifier with bit 0 clear does not match.
- R6: On a match, perm_out clears the write bit (bit 1) and keeps the read bit (bit 0) and execute bit (bit 2) as given in perm_in.
- R7: prot_fault is 1 exactly when acc_valid is 1, acc_type is write (2'd1), and a match exists. A read (2'd0), an execute (2'd2), or any access without acc_valid gives no fault.
- R8: With checking enabled and a non-zero acc_id that matches no register, perm_out equals perm_in.
- R9: A protection-ID register write made while psw_prot_en is 1 produces flush_req high for exactly the one following cycle. The same write made while psw_prot_en is 0 produces no flush.
- R10: Any change of psw_prot_en, 0 to 1 or 1 to 0, produces flush_req high for exactly the one following cycle.
- R11: flush_mask is all ones (4'hF) whenever flush_req is 1 and zero otherwise.
- R12: Each of the four registers can produce a match on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_we | input | 1 | Control-register write strobe |
| cr_idx | input | 5 | Control-register index |
| cr_wdata | input | 32 | Control-register write data |
| psw_prot_en | input | 1 | Protection-enable bit of the status word |
| acc_valid | input | 1 | Access strobe |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| acc_id | input | 31 | Access identifier of the translated page |
| perm_in | input | 3 | Page permissions: bit0 read, bit1 write, bit2 execute |
| perm_out | output | 3 | Filtered permissions, same encoding |
| prot_fault | output | 1 | Data protection fault for the current access |
| flush_req | output | 1 | One-cycle translation flush request |
| flush_mask | output | 4 | Translation contexts to flush |

## Verification
The hardest situations to reach from the ports are the identifier corners. Examples are a register holding 1, which would match a zero identifier if the public-page rule were missing, and a register whose identifier agrees but whose low bit is clear. The bench loads the registers with the enable bit low, so that the loads themselves cause no flush. It places these values in chosen slots and then walks a vector table across all four slots. The flush conditions are checked by toggling the enable bit and by writing the registers in both enable states. Each flush pulse is sampled one cycle and two cycles after the trigger.

// File: rtl/prot_id_pkg.sv
package prot_id_pkg;

    localparam int unsigned NUM_SLOTS  = 4;
    localparam int unsigned SLOT_SEL_W = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } perm_t;

    // Control indices 8, 9, 12 and 13 hold the protection IDs.
    function automatic logic is_pid_index(input logic [4:0] idx);
        return (idx == 5'd8) || (idx == 5'd9) || (idx == 5'd12) || (idx == 5'd13);
    endfunction

    function automatic logic [SLOT_SEL_W-1:0] slot_of(input logic [4:0] idx);
        logic [SLOT_SEL_W-1:0] s;
        case (idx)
            5'd9:    s = 2'd1;
            5'd12:   s = 2'd2;
            5'd13:   s = 2'd3;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pid_regfile.sv
module pid_regfile
    import prot_id_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]   pid_q,
    output logic                               pid_wr_hit
);

    logic [4:0] idx5;
    assign idx5       = 5'(wr_idx);
    assign pid_wr_hit = wr_en && is_pid_index(idx5);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                pid_q[s] <= '0;
            end else if (pid_wr_hit && (slot_of(idx5) == SLOT_SEL_W'(s))) begin
                pid_q[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pid_matcher.sv
module pid_matcher
    import prot_id_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned ID_W  = WORD_W - 1
) (
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0] pid_q,
    input  logic [ID_W-1:0]                  acc_id,
    input  logic                             prot_en,
    output logic                             id_hit
);

    logic [WORD_W-1:0]    probe;
    logic [NUM_SLOTS-1:0] slot_eq;

    // Identifier shifted up, write-disable flag forced on.
    assign probe = {acc_id, 1'b1};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        assign slot_eq[s] = (pid_q[s] == probe);
    end

    assign id_hit = prot_en && (acc_id != '0) && (|slot_eq);

endmodule

// File: rtl/flush_gen.sv
module flush_gen #(
    parameter int unsigned CTX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prot_en,
    input  logic             pid_wr_hit,
    output logic             flush_req,
    output logic [CTX_W-1:0] flush_mask
);

    logic en_q;
    logic trigger;

    assign trigger = (prot_en != en_q) || (pid_wr_hit && prot_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            en_q      <= prot_en;
            flush_req <= trigger;
        end
    end

    assign flush_mask = {CTX_W{flush_req}};

endmodule

// File: rtl/prot_id_guard.sv
module prot_id_guard
    import prot_id_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned CTX_W  = 4,
    localparam int unsigned ID_W  = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cr_we,
    input  logic [IDX_W-1:0]  cr_idx,
    input  logic [WORD_W-1:0] cr_wdata,
    input  logic              psw_prot_en,
    input  logic              acc_valid,
    input  logic [1:0]        acc_type,
    input  logic [ID_W-1:0]   acc_id,
    input  logic [2:0]        perm_in,
    output logic [2:0]        perm_out,
    output logic              prot_fault,
    output logic              flush_req,
    output logic [CTX_W-1:0]  flush_mask
);

    logic [NUM_SLOTS-1:0][WORD_W-1:0] pid_q;
    logic                             pid_wr_hit;
    logic                             id_hit;
    perm_t                            perm_raw;
    perm_t                            perm_flt;
    acc_kind_e                        kind;

    pid_regfile #(.WORD_W(WORD_W), .IDX_W(IDX_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cr_we),
        .wr_idx    (cr_idx),
        .wr_data   (cr_wdata),
        .pid_q     (pid_q),
        .pid_wr_hit(pid_wr_hit)
    );

    pid_matcher #(.WORD_W(WORD_W)) match_i (
        .pid_q  (pid_q),
        .acc_id (acc_id),
        .prot_en(psw_prot_en),
        .id_hit (id_hit)
    );

    flush_gen #(.CTX_W(CTX_W)) flush_i (
        .clk       (clk),
        .rst       (rst),
        .prot_en   (psw_prot_en),
        .pid_wr_hit(pid_wr_hit),
        .flush_req (flush_req),
        .flush_mask(flush_mask)
    );

    assign kind     = acc_kind_e'(acc_type);
    assign perm_raw = perm_t'(perm_in);

    always_comb begin
        perm_flt = perm_raw;
        if (id_hit) begin
            perm_flt.wr = 1'b0;
        end
    end

    assign perm_out   = perm_flt;
    assign prot_fault = acc_valid && id_hit && (kind == ACC_WRITE);

endmodule

// File: rtl/prot_id_guard_chk.sv
module prot_id_guard_chk
    import prot_id_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned ID_W  = 31,
    parameter int unsigned CTX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cr_we,
    input logic [IDX_W-1:0] cr_idx,
    input logic             psw_prot_en,
    input logic             acc_valid,
    input logic [1:0]       acc_type,
    input logic [ID_W-1:0]  acc_id,
    input logic [2:0]       perm_in,
    input logic [2:0]       perm_out,
    input logic             prot_fault,
    input logic             flush_req,
    input logic [CTX_W-1:0] flush_mask
);

    // R3
    disabled_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !psw_prot_en |-> (perm_out == perm_in) && !prot_fault);

    // R4
    public_page_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_id == '0) |-> (perm_out == perm_in) && !prot_fault);

    // R7
    fault_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> acc_valid && (acc_type == 2'd1));

    // R6
    fault_drops_write_chk: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> !perm_out[1] && (perm_out[0] == perm_in[0]) && (perm_out[2] == perm_in[2]));

    // R9
    pid_write_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (cr_we && is_pid_index(5'(cr_idx)) && psw_prot_en) |=> flush_req);

    // R10
    enable_toggle_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (psw_prot_en != $past(psw_prot_en)) |=> flush_req);

    // R11
    mask_full_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (flush_mask == {CTX_W{1'b1}}));

    // R11
    mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !flush_req |-> (flush_mask == '0));

endmodule

bind prot_id_guard prot_id_guard_chk #(.IDX_W(IDX_W), .ID_W(ID_W), .CTX_W(CTX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cr_we      (cr_we),
    .cr_idx     (cr_idx),
    .psw_prot_en(psw_prot_en),
    .acc_valid  (acc_valid),
    .acc_type   (acc_type),
    .acc_id     (acc_id),
    .perm_in    (perm_in),
    .perm_out   (perm_out),
    .prot_fault (prot_fault),
    .flush_req  (flush_req),
    .flush_mask (flush_mask)
);

// File: tb/prot_id_guard_tb_top.sv
`timescale 1ns/1ps
module prot_id_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cr_we = 1'b0;
    logic [4:0]  cr_idx = '0;
    logic [31:0] cr_wdata = '0;
    logic        psw_prot_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic [30:0] acc_id = '0;
    logic [2:0]  perm_in = '0;
    logic [2:0]  perm_out;
    logic        prot_fault;
    logic        flush_req;
    logic [3:0]  flush_mask;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prot_id_guard dut_i (
        .clk(clk), .rst(rst), .cr_we(cr_we), .cr_idx(cr_idx), .cr_wdata(cr_wdata),
        .psw_prot_en(psw_prot_en), .acc_valid(acc_valid), .acc_type(acc_type),
        .acc_id(acc_id), .perm_in(perm_in), .perm_out(perm_out),
        .prot_fault(prot_fault), .flush_req(flush_req), .flush_mask(flush_mask)
    );

    typedef struct packed {
        logic        en;
        logic        vld;
        logic [1:0]  kind;
        logic [30:0] id;
        logic [2:0]  pin;
        logic [2:0]  pexp;
        logic        fexp;
        logic [7:0]  req;
    } vec_t;

    // Registers at table time: idx8={123,1} idx9={55,1} idx12={100,0} idx13={7FFFFFFF,1}; idx10 written {77,1}
    localparam vec_t TBL [11] = '{
        '{1'b1, 1'b1, 2'd1, 31'h123,      3'b111, 3'b101, 1'b1, 8'd7},  // R7 write fault
        '{1'b1, 1'b1, 2'd0, 31'h123,      3'b111, 3'b101, 1'b0, 8'd6},  // R6 read keeps rd/ex
        '{1'b1, 1'b1, 2'd2, 31'h55,       3'b111, 3'b101, 1'b0, 8'd12}, // R12 second slot
        '{1'b1, 1'b1, 2'd1, 31'h7FFFFFFF, 3'b111, 3'b101, 1'b1, 8'd12}, // R12 fourth slot
        '{1'b1, 1'b1, 2'd1, 31'h100,      3'b111, 3'b111, 1'b0, 8'd5},  // R5 low bit clear
        '{1'b1, 1'b1, 2'd1, 31'h77,       3'b111, 3'b111, 1'b0, 8'd2},  // R2 index 10 ignored
        '{1'b0, 1'b1, 2'd1, 31'h123,      3'b111, 3'b111, 1'b0, 8'd3},  // R3 disabled
        '{1'b1, 1'b0, 2'd1, 31'h123,      3'b111, 3'b101, 1'b0, 8'd7},  // R7 no strobe
        '{1'b1, 1'b1, 2'd1, 31'h42,       3'b011, 3'b011, 1'b0, 8'd8},  // R8 no match
        '{1'b1, 1'b1, 2'd1, 31'h0,        3'b111, 3'b111, 1'b0, 8'd4},  // R4 public
        '{1'b1, 1'b1, 2'd0, 31'h123,      3'b001, 3'b001, 1'b0, 8'd6}   // R6 read only
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cr_write(input logic [4:0] idx, input logic [31:0] data);
        @(negedge clk);
        cr_we = 1'b1; cr_idx = idx; cr_wdata = data;
        @(negedge clk);
        cr_we = 1'b0;
    endtask

    task automatic access(input logic en, input logic vld, input logic [1:0] kind,
                          input logic [30:0] id, input logic [2:0] pin);
        psw_prot_en = en; acc_valid = vld; acc_type = kind; acc_id = id; perm_in = pin;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 flush_req", 32'(flush_req), 32'd0);
        check("R1 flush_mask", 32'(flush_mask), 32'd0);
        access(1'b0, 1'b1, 2'd1, 31'h0, 3'b111);
        check("R1 zero regs do not match (psw off)", 32'(perm_out), 32'b111);
        // R1: with enable raised, empty registers still match nothing
        access(1'b1, 1'b1, 2'd1, 31'h123, 3'b111);
        check("R1 perm", 32'(perm_out), 32'b111);
        check("R1 fault", 32'(prot_fault), 32'd0);
        @(negedge clk);
        @(negedge clk);
        access(1'b0, 1'b0, 2'd0, 31'h0, 3'b000);
        @(negedge clk);
        @(negedge clk);

        // Load registers with checking off: no flush expected (R9)
        cr_write(5'd8,  {31'h123, 1'b1});
        check("R9 no flush when disabled", 32'(flush_req), 32'd0);
        cr_write(5'd9,  {31'h55, 1'b1});
        cr_write(5'd12, {31'h100, 1'b0});
        cr_write(5'd13, {31'h7FFFFFFF, 1'b1});
        cr_write(5'd10, {31'h77, 1'b1});

        for (int i = 0; i < 11; i++) begin
            access(TBL[i].en, TBL[i].vld, TBL[i].kind, TBL[i].id, TBL[i].pin);
            check($sformatf("R%0d perm vec %0d", TBL[i].req, i), 32'(perm_out), 32'(TBL[i].pexp));
            check($sformatf("R%0d fault vec %0d", TBL[i].req, i), 32'(prot_fault), 32'(TBL[i].fexp));
        end

        // R10: enable toggles
        @(negedge clk);
        psw_prot_en = 1'b0;
        repeat (2) @(negedge clk);
        psw_prot_en = 1'b1;
        @(negedge clk);
        check("R10 rise flush", 32'(flush_req), 32'd1);
        check("R11 mask full", 32'(flush_mask), 32'hF);
        @(negedge clk);
        check("R10 rise pulse ends", 32'(flush_req), 32'd0);
        check("R11 mask idle", 32'(flush_mask), 32'h0);
        psw_prot_en = 1'b0;
        @(negedge clk);
        check("R10 fall flush", 32'(flush_req), 32'd1);
        @(negedge clk);
        check("R10 fall pulse ends", 32'(flush_req), 32'd0);

        // R9: register write with checking on
        psw_prot_en = 1'b1;
        repeat (2) @(negedge clk);
        cr_write(5'd12, {31'h100, 1'b1});
        check("R9 flush on pid write", 32'(flush_req), 32'd1);
        check("R11 mask on pid write", 32'(flush_mask), 32'hF);
        @(negedge clk);
        check("R9 pulse one cycle", 32'(flush_req), 32'd0);
        access(1'b1, 1'b1, 2'd1, 31'h100, 3'b111);
        check("R12 third slot perm", 32'(perm_out), 32'b101);
        check("R12 third slot fault", 32'(prot_fault), 32'd1);

        // R2: non-PID index gives no flush
        cr_write(5'd10, {31'h42, 1'b1});
        check("R2 no flush on other index", 32'(flush_req), 32'd0);
        access(1'b1, 1'b1, 2'd1, 31'h42, 3'b111);
        check("R2 other index no match", 32'(perm_out), 32'b111);

        // R4: register holding 1 must not catch identifier 0
        cr_write(5'd13, 32'h1);
        access(1'b1, 1'b1, 2'd1, 31'h0, 3'b111);
        check("R4 public perm", 32'(perm_out), 32'b111);
        check("R4 public fault", 32'(prot_fault), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule